// File: doc/BRIEF.md
# Timing-Slave Pixel Input Capture

This block is the receive front end of a video encoder that supplies the clock but takes its timing from a graphics controller. The encoder's own clock is forwarded to the controller as a frequency reference. The controller sends back a clock at that rate, along with pixel data and three active-low timing strobes: horizontal sync, vertical sync and blanking. All capture runs on the returned clock.

A falling edge on horizontal sync opens a line, and a falling edge on vertical sync opens a frame. The first active pixel of a line can be found in one of two ways, chosen by a static input. In blanking mode, it is the pixel at which the blanking strobe goes high. This absorbs the extra 8 or 9 clocks that a character-clocked controller adds after sync. In offset mode, it lies a programmed number of samples after the sync edge, which suits sources that are timed per pixel.

The data bus can be used in either of two ways. It can carry one byte on each clock edge, and the two bytes are paired into one word. It can also carry a full 24-bit pixel once per clock. Each pixel leaves the block as a word with valid, start-of-line and start-of-frame flags.

Top module: `vcap_top`

## Requirements
- R1: `ref_clk_o` carries the level of `enc_clk` at all times.
- R2: The strobe inputs are active low. A line or frame starts only on a high-to-low change between two successive rising-edge samples. Holding a strobe low does not start it again.
- R3: A pixel sampled on rising edge k appears on the outputs after rising edge k+1.
- R4: With `blank_en`=1, a pixel is valid exactly when its sampled `blank_n` is 1. `px_sol` marks the first valid sample that follows a sample with `blank_n`=0.
- R5: With `blank_en`=1, the start of line follows the blanking release, whether that release comes 8 or 9 samples after the horizontal sync edge.
- R6: With `blank_en`=0, the sync-edge sample has index 0. Samples with index below `hs_offset` are invalid. The sample at index `hs_offset` is valid and carries `px_sol`. Later samples stay valid. `blank_n` has no effect in this mode. Nothing is valid before the first horizontal sync edge after reset.
- R7: With `blank_en`=0 and `hs_offset`=0, the sync-edge sample is itself valid and marks start of line.
- R8: When `mode` is any value other than 4'b0111, `px_data` = {8'h00, the `pd[7:0]` value taken on the falling edge, the `pd[7:0]` value taken on the preceding rising edge}.
- R9: When `mode` = 4'b0111, `px_data` equals all 24 bits of `pd` taken on the rising edge. Values that `pd` holds at the falling edge are ignored.
- R10: `px_sof` is set on the first valid pixel at or after a vertical sync edge, and only once per edge.
- R11: When `px_valid` is 0, `px_data` is zero and both flags are 0.
- R12: While `rst` is high at a rising edge, every output except `ref_clk_o` is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock returned by the controller; capture clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_clk | input | 1 | Encoder master clock |
| ref_clk_o | output | 1 | Reference clock forwarded to the controller |
| mode | input | 4 | Bus mode; 4'b0111 selects 24-bit single-edge capture |
| blank_en | input | 1 | 1: blanking strobe places the first pixel; 0: programmed offset does |
| hs_offset | input | 12 | Index of the first active sample after horizontal sync, in offset mode |
| pd | input | 24 | Pixel data bus |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| blank_n | input | 1 | Blanking, active low |
| px_data | output | 24 | Captured pixel word |
| px_valid | output | 1 | Pixel word is active video |
| px_sol | output | 1 | First pixel of a line |
| px_sof | output | 1 | First pixel of a frame |

## Verification
Every output comes one rising edge after the edge that sampled its pixel. The paired byte in the narrow mode is taken on the falling edge between those two rising edges. The per-pixel task drives the rising-edge byte and the strobes just after a falling edge, and drives the second byte just after the rising edge. One nanosecond after that same rising edge, it compares the outputs against the expectation stored by the previous call. Each check therefore lands on the cycle in which that result is due. Offset counts and gaps are stated in samples, with the sync-edge sample as index 0, so the offset and skew cases check the exact position of the start of line.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam logic [3:0] MODE_WIDE24 = 4'b0111;

    // registered strobe levels (active-low encoding kept as on the pins)
    typedef struct packed {
        logic hs;
        logic vs;
        logic bl;
    } strobe_t;

    // events extracted from two successive strobe samples
    typedef struct packed {
        logic line_edge;
        logic frame_edge;
        logic blank_end;
        logic blank_lvl;
    } strobe_ev_t;

    localparam strobe_t STROBE_IDLE = '{hs: 1'b1, vs: 1'b1, bl: 1'b0};

    function automatic logic is_wide(input logic [3:0] m);
        return m == MODE_WIDE24;
    endfunction

endpackage

// File: rtl/vcap_sync_det.sv
module vcap_sync_det
    import vcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_n,
    input  logic       vsync_n,
    input  logic       blank_n,
    output strobe_ev_t ev
);
    strobe_t cur_q;
    strobe_t prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= STROBE_IDLE;
            prv_q <= STROBE_IDLE;
        end else begin
            cur_q <= '{hs: hsync_n, vs: vsync_n, bl: blank_n};
            prv_q <= cur_q;
        end
    end

    always_comb begin
        ev.line_edge  = prv_q.hs & ~cur_q.hs;
        ev.frame_edge = prv_q.vs & ~cur_q.vs;
        ev.blank_end  = ~prv_q.bl & cur_q.bl;
        ev.blank_lvl  = cur_q.bl;
    end

endmodule

// File: rtl/vcap_data_cap.sv
module vcap_data_cap #(
    parameter int WIDE_W   = 24,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic [WIDE_W-1:0] pd,
    output logic [WIDE_W-1:0] word
);
    localparam int PAIR_W = 2 * NARROW_W;
    localparam int PAD_W  = WIDE_W - PAIR_W;

    logic [WIDE_W-1:0]   rise_q;
    logic [NARROW_W-1:0] fall_q;
    logic [PAIR_W-1:0]   pair;
    logic [WIDE_W-1:0]   narrow_word;

    always_ff @(posedge clk) begin
        if (rst) rise_q <= '0;
        else     rise_q <= pd;
    end

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= pd[NARROW_W-1:0];
    end

    assign pair = {fall_q, rise_q[NARROW_W-1:0]};

    generate
        if (PAD_W > 0) begin : g_pad
            assign narrow_word = {{PAD_W{1'b0}}, pair};
        end else begin : g_nopad
            assign narrow_word = pair[WIDE_W-1:0];
        end
    endgenerate

    assign word = wide_mode ? rise_q : narrow_word;

endmodule

// File: rtl/vcap_line_ctl.sv
module vcap_line_ctl
    import vcap_pkg::*;
#(
    parameter int OFFS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blank_en,
    input  logic [OFFS_W-1:0] hs_offset,
    input  strobe_ev_t        ev,
    output logic              active,
    output logic              sol,
    output logic              sof
);
    localparam int CW = OFFS_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic [CW-1:0] target;
    logic          seen_q;
    logic          sof_pend_q;
    logic          act_off;
    logic          sol_off;

    assign target  = {1'b0, hs_offset};
    assign idx     = ev.line_edge ? '0 : cnt_q;
    assign act_off = (seen_q | ev.line_edge) & (idx >= target);
    assign sol_off = act_off & (idx == target);

    always_comb begin
        if (blank_en) begin
            active = ev.blank_lvl;
            sol    = ev.blank_end;
        end else begin
            active = act_off;
            sol    = sol_off;
        end
        sof = active & (sof_pend_q | ev.frame_edge);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            seen_q     <= 1'b0;
            sof_pend_q <= 1'b0;
        end else begin
            if (ev.line_edge) begin
                cnt_q  <= CW'(1);
                seen_q <= 1'b1;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
            sof_pend_q <= (sof_pend_q | ev.frame_edge) & ~sof;
        end
    end

endmodule

// File: rtl/vcap_top.sv
module vcap_top
    import vcap_pkg::*;
#(
    parameter int WIDE_W   = 24,
    parameter int NARROW_W = 8,
    parameter int OFFS_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_clk,
    output logic              ref_clk_o,
    input  logic [3:0]        mode,
    input  logic              blank_en,
    input  logic [OFFS_W-1:0] hs_offset,
    input  logic [WIDE_W-1:0] pd,
    input  logic              hsync_n,
    input  logic              vsync_n,
    input  logic              blank_n,
    output logic [WIDE_W-1:0] px_data,
    output logic              px_valid,
    output logic              px_sol,
    output logic              px_sof
);
    strobe_ev_t        ev;
    logic [WIDE_W-1:0] word;
    logic              active;
    logic              sol;
    logic              sof;

    // R1: reference clock forwarded to the controller
    assign ref_clk_o = enc_clk;

    vcap_sync_det u_sync (
        .clk     (clk),
        .rst     (rst),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .blank_n (blank_n),
        .ev      (ev)
    );

    vcap_data_cap #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (is_wide(mode)),
        .pd        (pd),
        .word      (word)
    );

    vcap_line_ctl #(.OFFS_W(OFFS_W)) u_line (
        .clk       (clk),
        .rst       (rst),
        .blank_en  (blank_en),
        .hs_offset (hs_offset),
        .ev        (ev),
        .active    (active),
        .sol       (sol),
        .sof       (sof)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            px_data  <= '0;
            px_valid <= 1'b0;
            px_sol   <= 1'b0;
            px_sof   <= 1'b0;
        end else begin
            px_data  <= active ? word : '0;
            px_valid <= active;
            px_sol   <= active & sol;
            px_sof   <= sof;
        end
    end

endmodule

// File: rtl/vcap_chk.sv
module vcap_chk
    import vcap_pkg::*;
#(
    parameter int WIDE_W   = 24,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        mode,
    input logic              blank_en,
    input logic [WIDE_W-1:0] px_data,
    input logic              px_valid,
    input logic              px_sol,
    input logic              px_sof
);
    p_sol_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
        px_sol |-> px_valid);

    p_sof_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        px_sof |-> px_valid);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !px_valid |-> (px_data == '0));

    p_sof_single_r10: assert property (@(posedge clk) disable iff (rst)
        px_sof |=> !px_sof);

    p_narrow_pad_r8: assert property (@(posedge clk) disable iff (rst)
        (!is_wide(mode) && $stable(mode) && px_valid) |-> ((px_data >> (2 * NARROW_W)) == '0));

    p_sol_after_blank_r4: assert property (@(posedge clk) disable iff (rst)
        (blank_en && $past(blank_en) && px_sol) |-> !$past(px_valid));

endmodule

bind vcap_top vcap_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .blank_en (blank_en),
    .px_data  (px_data),
    .px_valid (px_valid),
    .px_sol   (px_sol),
    .px_sof   (px_sof)
);

// File: tb/sim_vcap_top.sv
module sim_vcap_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        enc_clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = 4'b0000;
    logic        blank_en = 1'b1;
    logic [11:0] hs_offset = '0;
    logic [23:0] pd = '0;
    logic        hsync_n = 1'b1;
    logic        vsync_n = 1'b1;
    logic        blank_n = 1'b0;
    logic        ref_clk_o;
    logic [23:0] px_data;
    logic        px_valid, px_sol, px_sof;

    int n_chk = 0;
    int n_fail = 0;

    // expectation of the pixel driven in the previous step
    logic        p_ok = 1'b0;
    logic        p_v, p_s, p_f;
    logic [23:0] p_d;
    string       p_tag;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always #7 enc_clk = ~enc_clk;

    vcap_top u0 (
        .clk(clk), .rst(rst), .enc_clk(enc_clk), .ref_clk_o(ref_clk_o),
        .mode(mode), .blank_en(blank_en), .hs_offset(hs_offset), .pd(pd),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
        .px_data(px_data), .px_valid(px_valid), .px_sol(px_sol), .px_sof(px_sof)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // R3: outputs for the pixel of one step are compared just after the next rising edge
    task automatic step(input logic [23:0] lo, input logic [7:0] hi,
                        input logic hs, input logic vs, input logic bl,
                        input logic ev, input logic es, input logic ef,
                        input logic [23:0] ed, input string tag);
        @(negedge clk); #1;
        pd = lo; hsync_n = hs; vsync_n = vs; blank_n = bl;
        @(posedge clk); #1;
        pd = {hi, hi, hi};
        if (p_ok) begin
            check({p_tag, " valid"}, 32'(px_valid), 32'(p_v));
            check({p_tag, " sol"},   32'(px_sol),   32'(p_s));
            check({p_tag, " sof"},   32'(px_sof),   32'(p_f));
            check({p_tag, " data"},  {8'h0, px_data}, {8'h0, p_d});
        end
        p_ok = 1'b1; p_v = ev; p_s = es; p_f = ef; p_d = ed; p_tag = tag;
    endtask

    task automatic idle(input logic vs, input string tag);
        step(24'h0, 8'h0, 1'b1, vs, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pd = '0; hsync_n = 1'b1; vsync_n = 1'b1; blank_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        p_ok = 1'b0;
    endtask

    // R12 and R1
    task automatic t_reset();
        do_reset();
        check("R12 valid", 32'(px_valid), 32'h0);
        check("R12 sol",   32'(px_sol),   32'h0);
        check("R12 sof",   32'(px_sof),   32'h0);
        check("R12 data",  {8'h0, px_data}, 32'h0);
        #3;  check("R1 ref clock", 32'(ref_clk_o), 32'(enc_clk));
        #8;  check("R1 ref clock", 32'(ref_clk_o), 32'(enc_clk));
    endtask

    // R4, R5, R8, R10: blanking-placed pixels on the dual-edge byte bus
    task automatic t_blank_narrow();
        mode = 4'b0000; blank_en = 1'b1;
        do_reset();
        idle(1'b1, "R4 idle");
        idle(1'b0, "R10 vsync edge in blanking");
        // line with 8-sample slip
        step(24'h0, 8'h0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 24'h0, "R2 hsync edge");
        for (int i = 0; i < 7; i++) idle(1'b0, "R5 slip 8");
        step(24'hFF3344, 8'h55, 1'b1, 1'b0, 1'b1, 1, 1, 1, 24'h005544, "R8 first pixel");
        step(24'h000066, 8'h77, 1'b1, 1'b0, 1'b1, 1, 0, 0, 24'h007766, "R4 second pixel");
        idle(1'b0, "R11 blanked");
        // line with 9-sample slip
        step(24'h0, 8'h0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 24'h0, "R2 hsync edge");
        for (int i = 0; i < 8; i++) idle(1'b0, "R5 slip 9");
        step(24'h1234AB, 8'hCD, 1'b1, 1'b0, 1'b1, 1, 1, 0, 24'h00CDAB, "R5 start after slip 9");
        idle(1'b0, "R4 end");
        idle(1'b0, "R4 flush");
    endtask

    // R6, R9, R2: offset-placed pixels on the wide bus
    task automatic t_offset_wide();
        mode = 4'b0111; blank_en = 1'b0; hs_offset = 12'd5;
        do_reset();
        step(24'h111111, 8'hEE, 1'b1, 1'b1, 1'b1, 0, 0, 0, 24'h0, "R6 no line yet");
        step(24'h222222, 8'hEE, 1'b1, 1'b1, 1'b1, 0, 0, 0, 24'h0, "R6 no line yet");
        step(24'h000000, 8'hEE, 1'b0, 1'b0, 1'b0, 0, 0, 0, 24'h0, "R6 index 0");
        step(24'h000001, 8'hEE, 1'b0, 1'b0, 1'b1, 0, 0, 0, 24'h0, "R2 held low");
        for (int i = 2; i < 5; i++)
            step(24'h000002, 8'hEE, 1'b1, 1'b0, 1'b1, 0, 0, 0, 24'h0, "R6 before offset");
        step(24'hA1B2C3, 8'hEE, 1'b1, 1'b0, 1'b0, 1, 1, 1, 24'hA1B2C3, "R9 at offset");
        step(24'h0D0E0F, 8'h99, 1'b1, 1'b0, 1'b1, 1, 0, 0, 24'h0D0E0F, "R6 after offset");
        step(24'h000003, 8'hEE, 1'b0, 1'b0, 1'b1, 0, 0, 0, 24'h0, "R2 new line");
        for (int i = 1; i < 5; i++)
            step(24'h000004, 8'hEE, 1'b1, 1'b0, 1'b1, 0, 0, 0, 24'h0, "R6 before offset");
        step(24'h445566, 8'hEE, 1'b1, 1'b0, 1'b0, 1, 1, 0, 24'h445566, "R6 second line");
        step(24'h0, 8'h0, 1'b1, 1'b0, 1'b0, 1, 0, 0, 24'h0, "R6 flush");
        step(24'h0, 8'h0, 1'b1, 1'b0, 1'b0, 1, 0, 0, 24'h0, "R6 flush");
    endtask

    // R7
    task automatic t_offset_zero();
        mode = 4'b0111; blank_en = 1'b0; hs_offset = 12'd0;
        do_reset();
        step(24'h0, 8'h0, 1'b1, 1'b1, 1'b0, 0, 0, 0, 24'h0, "R7 idle");
        step(24'h765432, 8'h11, 1'b0, 1'b1, 1'b0, 1, 1, 0, 24'h765432, "R7 edge pixel");
        step(24'h000777, 8'h11, 1'b1, 1'b1, 1'b0, 1, 0, 0, 24'h000777, "R7 next");
        step(24'h000888, 8'h11, 1'b0, 1'b1, 1'b0, 1, 1, 0, 24'h000888, "R7 next line");
        step(24'h0, 8'h0, 1'b1, 1'b1, 1'b0, 1, 0, 0, 24'h0, "R7 flush");
        step(24'h0, 8'h0, 1'b1, 1'b1, 1'b0, 1, 0, 0, 24'h0, "R7 flush");
    endtask

    // R10: start of frame once per vsync edge
    task automatic t_frame();
        mode = 4'b0000; blank_en = 1'b1;
        do_reset();
        idle(1'b1, "R10 idle");
        idle(1'b0, "R10 edge blanked");
        idle(1'b0, "R10 held low");
        step(24'h000010, 8'h20, 1'b1, 1'b0, 1'b1, 1, 1, 1, 24'h002010, "R10 deferred sof");
        step(24'h000030, 8'h40, 1'b1, 1'b0, 1'b1, 1, 0, 0, 24'h004030, "R10 no repeat");
        step(24'h000050, 8'h60, 1'b1, 1'b1, 1'b1, 1, 0, 0, 24'h006050, "R10 vsync high");
        step(24'h000070, 8'h80, 1'b1, 1'b0, 1'b1, 1, 0, 1, 24'h008070, "R10 sof mid line");
        idle(1'b0, "R10 flush");
        idle(1'b0, "R10 flush");
    endtask

    initial begin
        t_reset();
        t_blank_narrow();
        t_offset_wide();
        t_offset_zero();
        t_frame();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule